// File: doc/BRIEF.md
# Host Control and Status Register with Interrupt Gating

This block sits at a single host bus address of a DSP board. A host write there loads an eight-bit control register that is never readable. A host read at the same address returns a status byte instead. The control bits hold the DSP and its state machines in reset, enable read prefetch, enable two interrupt sources, hold the MIDI UART in reset, and pre-select the range of the S/PDIF input PLL.

The block also gates two DSP-side lines onto one shared active-low bus interrupt: the host-request line and a general-purpose DSP pin. Each line first passes through a two-flop synchroniser. It then goes through its own enable bit. The status byte shows three buffer-empty flags taken from the transfer FIFOs.

An asynchronous active-low reset clears everything at once. Its release is synchronised to the clock. After reset the DSP is halted and every interrupt is masked, until software writes the control register.

Top module: `hostctl_regs`

## Requirements
- R1: While reset is active and after it, until the first write, all control outputs are 0. That means dsp_rst_n=0, prefetch_en=0, midi_rst=0, pll_sel=0, and irq_n=1.
- R2: A write is a clock edge with cs=1 and wr=1. It loads wdata, and the control outputs show the new value from that edge on.
- R3: Control bit 7 drives dsp_rst_n directly. Writing 0 holds the DSP in reset and writing 1 releases it.
- R4: Control bit 6 drives prefetch_en. Bit 3 drives midi_rst, where 1 holds the UART in reset. Bit 2 drives pll_sel, where 0 selects 44.1/48 kHz and 1 selects 32 kHz.
- R5: Control bits 1 and 0 have no effect on any output.
- R6: With cs=1 and wr=0, rdata returns the status byte and never the control value. In that byte, bit 4 is addr_empty, bit 5 is wfifo_empty, bit 6 is rfifo_empty, and bits 7 and 3..0 are 0.
- R7: When no read is in progress, rdata is 0.
- R8: irq_n is 0 exactly when (synchronised dsp_hreq AND control bit 4) OR (synchronised dsp_gpio AND control bit 5) is true.
- R9: dsp_hreq and dsp_gpio reach irq_n through two flip-flops. A change shows on irq_n after the second rising edge following it. A change of an enable bit acts from the write edge on.
- R10: An edge with cs=0 or wr=0 leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for the register address |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Status byte on reads, else 0 |
| addr_empty | input | 1 | Address FIFO empty flag |
| wfifo_empty | input | 1 | Write-data FIFO empty flag |
| rfifo_empty | input | 1 | Read-data FIFO empty flag |
| dsp_hreq | input | 1 | DSP host-request line, asynchronous |
| dsp_gpio | input | 1 | DSP general-purpose pin, asynchronous |
| dsp_rst_n | output | 1 | DSP and state-machine reset, active low |
| prefetch_en | output | 1 | Read prefetch enable |
| midi_rst | output | 1 | MIDI UART reset, active high |
| pll_sel | output | 1 | PLL range pre-select |
| irq_n | output | 1 | Shared bus interrupt, active low |

## Verification
The following are checked on every cycle:
- Each write lands in the outputs on the next cycle.
- Idle and read cycles leave the outputs stable.
- A read shows only the status flags, with zeros in the unused bits.
- A low irq_n always has at least one enable set behind it.
- A falling irq_n under steady enables traces back to a DSP line that was high two cycles earlier.

Only the bench scenarios can show the following:
- The exact two-edge synchroniser latency.
- That the spare bits are ignored, shown by comparing outputs after different writes.
- The reset state.
- Which input drives which interrupt, and that each interrupt source is masked on its own.

// File: rtl/hostctl_pkg.sv
package hostctl_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic       run;       // bit 7: 1 releases DSP reset
    logic       pref;      // bit 6
    logic       gpio_ie;   // bit 5
    logic       hreq_ie;   // bit 4
    logic       uart_rst;  // bit 3
    logic       pll32;     // bit 2
    logic [1:0] spare;     // bits 1..0, ignored
  } ctrl_t;

  localparam int unsigned ST_ADDR_BIT = 4;
  localparam int unsigned ST_WR_BIT   = 5;
  localparam int unsigned ST_RD_BIT   = 6;
endpackage

// File: rtl/hostctl_sync.sv
module hostctl_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_nxt;

  always_comb begin
    stg_nxt[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_nxt[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_nxt;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hostctl_reg.sv
module hostctl_reg
  import hostctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              addr_empty,
  input  logic              wfifo_empty,
  input  logic              rfifo_empty,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata
);
  logic  wr_en;
  logic  rd_en;
  ctrl_t ctrl_nxt;

  assign wr_en = cs & wr;
  assign rd_en = cs & ~wr;

  always_comb begin
    ctrl_nxt       = ctrl_t'(wdata);
    ctrl_nxt.spare = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl <= ctrl_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      rdata[ST_ADDR_BIT] = addr_empty;
      rdata[ST_WR_BIT]   = wfifo_empty;
      rdata[ST_RD_BIT]   = rfifo_empty;
    end
  end
endmodule

// File: rtl/hostctl_irq.sv
module hostctl_irq #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] en,
  output logic            irq_n
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign hit[g] = src[g] & en[g];
  end

  assign irq_n = ~(|hit);
endmodule

// File: rtl/hostctl_regs.sv
module hostctl_regs
  import hostctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              addr_empty,
  input  logic              wfifo_empty,
  input  logic              rfifo_empty,
  input  logic              dsp_hreq,
  input  logic              dsp_gpio,
  output logic              dsp_rst_n,
  output logic              prefetch_en,
  output logic              midi_rst,
  output logic              pll_sel,
  output logic              irq_n
);
  logic       rst_int_n;
  logic [1:0] line_raw;
  logic [1:0] line_s;
  logic [1:0] line_en;
  ctrl_t      ctrl_q;

  hostctl_sync #(.WIDTH(1), .STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  assign line_raw = {dsp_gpio, dsp_hreq};

  hostctl_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (line_raw),
    .q     (line_s)
  );

  hostctl_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs          (cs),
    .wr          (wr),
    .wdata       (wdata),
    .addr_empty  (addr_empty),
    .wfifo_empty (wfifo_empty),
    .rfifo_empty (rfifo_empty),
    .ctrl        (ctrl_q),
    .rdata       (rdata)
  );

  assign line_en = {ctrl_q.gpio_ie, ctrl_q.hreq_ie};

  hostctl_irq #(.NSRC(2)) u_irq (
    .src   (line_s),
    .en    (line_en),
    .irq_n (irq_n)
  );

  assign dsp_rst_n   = ctrl_q.run;
  assign prefetch_en = ctrl_q.pref;
  assign midi_rst    = ctrl_q.uart_rst;
  assign pll_sel     = ctrl_q.pll32;
endmodule

// File: rtl/hostctl_regs_chk.sv
module hostctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_int_n,
  input logic       cs,
  input logic       wr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       addr_empty,
  input logic       wfifo_empty,
  input logic       rfifo_empty,
  input logic       dsp_hreq,
  input logic       dsp_gpio,
  input logic       dsp_rst_n,
  input logic       prefetch_en,
  input logic       midi_rst,
  input logic       pll_sel,
  input logic       irq_n,
  input logic [7:0] ctrl_bits
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (!dsp_rst_n && !prefetch_en && !midi_rst && !pll_sel && irq_n); // R1
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs && wr) |=> (dsp_rst_n == $past(wdata[7])) && (prefetch_en == $past(wdata[6]))
                   && (midi_rst == $past(wdata[3])) && (pll_sel == $past(wdata[2]))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cs && wr) |=> $stable(dsp_rst_n) && $stable(prefetch_en) && $stable(midi_rst)
                    && $stable(pll_sel) && $stable(ctrl_bits)); // R10

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs && !wr) |-> (rdata[6] == rfifo_empty) && (rdata[5] == wfifo_empty)
                    && (rdata[4] == addr_empty) && (rdata[7] == 1'b0) && (rdata[3:0] == 4'h0)); // R6

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cs && !wr) |-> (rdata == 8'h00)); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq_n |-> (ctrl_bits[4] || ctrl_bits[5])); // R8

  AST_IRQ_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(irq_n) && $stable(ctrl_bits)) |-> ($past(dsp_hreq, 2) || $past(dsp_gpio, 2))); // R9
endmodule

bind hostctl_regs hostctl_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_int_n   (rst_int_n),
  .cs          (cs),
  .wr          (wr),
  .wdata       (wdata),
  .rdata       (rdata),
  .addr_empty  (addr_empty),
  .wfifo_empty (wfifo_empty),
  .rfifo_empty (rfifo_empty),
  .dsp_hreq    (dsp_hreq),
  .dsp_gpio    (dsp_gpio),
  .dsp_rst_n   (dsp_rst_n),
  .prefetch_en (prefetch_en),
  .midi_rst    (midi_rst),
  .pll_sel     (pll_sel),
  .irq_n       (irq_n),
  .ctrl_bits   (ctrl_q)
);

// File: tb/hostctl_regs_bench.sv
module hostctl_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       addr_empty, wfifo_empty, rfifo_empty;
  logic       dsp_hreq, dsp_gpio;
  logic       dsp_rst_n, prefetch_en, midi_rst, pll_sel, irq_n;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  hostctl_regs u_hostctl_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .wdata(wdata), .rdata(rdata),
    .addr_empty(addr_empty), .wfifo_empty(wfifo_empty), .rfifo_empty(rfifo_empty),
    .dsp_hreq(dsp_hreq), .dsp_gpio(dsp_gpio), .dsp_rst_n(dsp_rst_n),
    .prefetch_en(prefetch_en), .midi_rst(midi_rst), .pll_sel(pll_sel), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {dsp_rst_n, prefetch_en, midi_rst, pll_sel, irq_n, 3'b000};
  endfunction

  function automatic logic [7:0] exp_outs(input logic [7:0] c, input logic h, input logic g);
    logic irq;
    irq = (h & c[4]) | (g & c[5]);
    return {c[7], c[6], c[3], c[2], ~irq, 3'b000};
  endfunction

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; wdata = v;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), exp_outs(8'h00, 1'b0, 1'b0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", outs(), exp_outs(8'h00, 1'b0, 1'b0));
    check("R7 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_fields();
    wr_reg(8'h80);
    check("R3 dsp release", outs(), exp_outs(8'h80, 1'b0, 1'b0));
    wr_reg(8'h40);
    check("R3 dsp held", outs(), exp_outs(8'h40, 1'b0, 1'b0));
    wr_reg(8'h0C);
    check("R4 uart and pll", outs(), exp_outs(8'h0C, 1'b0, 1'b0));
    wr_reg(8'hC4);
    check("R2 pattern C4", outs(), exp_outs(8'hC4, 1'b0, 1'b0));
  endtask

  task automatic t_spare();
    logic [7:0] ref_o;
    wr_reg(8'hCC);
    ref_o = outs();
    wr_reg(8'hCF);
    check("R5 spare bits set", outs(), ref_o);
    wr_reg(8'h03);
    check("R5 spare only", outs(), exp_outs(8'h00, 1'b0, 1'b0));
  endtask

  task automatic t_nowrite();
    wr_reg(8'h84);
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; wdata = 8'h48;
    @(negedge clk);
    check("R10 cs low", outs(), exp_outs(8'h84, 1'b0, 1'b0));
    cs = 1'b1; wr = 1'b0;
    @(negedge clk);
    check("R10 read cycle", outs(), exp_outs(8'h84, 1'b0, 1'b0));
    cs = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic t_status();
    logic [7:0] e;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      addr_empty = i[0]; wfifo_empty = i[1]; rfifo_empty = i[2];
      cs = 1'b1; wr = 1'b0;
      #1;
      e = {1'b0, i[2], i[1], i[0], 4'h0};
      check("R6 status read", rdata, e);
    end
    @(negedge clk);
    cs = 1'b0;
    #1;
    check("R7 no read", rdata, 8'h00);
    cs = 1'b1; wr = 1'b1; wdata = 8'hFF;
    #1;
    check("R7 write cycle", rdata, 8'h00);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic t_irq();
    wr_reg(8'h10);
    dsp_hreq = 1'b1; dsp_gpio = 1'b0;
    @(posedge clk); #1;
    check("R9 one edge", {7'h0, irq_n}, 8'h01);
    @(posedge clk); #1;
    check("R9 two edges", {7'h0, irq_n}, 8'h00);
    @(negedge clk);
    check("R8 hreq enabled", outs(), exp_outs(8'h10, 1'b1, 1'b0));
    wr_reg(8'h20);
    check("R8 hreq masked", outs(), exp_outs(8'h20, 1'b1, 1'b0));
    dsp_hreq = 1'b0; dsp_gpio = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 gpio enabled", outs(), exp_outs(8'h20, 1'b0, 1'b1));
    wr_reg(8'h10);
    check("R8 gpio masked", outs(), exp_outs(8'h10, 1'b0, 1'b1));
    dsp_hreq = 1'b1;
    repeat (2) @(negedge clk);
    wr_reg(8'h30);
    check("R8 both", outs(), exp_outs(8'h30, 1'b1, 1'b1));
    dsp_hreq = 1'b0; dsp_gpio = 1'b0;
    @(posedge clk); #1;
    check("R9 deassert one edge", {7'h0, irq_n}, 8'h00);
    @(posedge clk); #1;
    check("R9 deassert two edges", {7'h0, irq_n}, 8'h01);
  endtask

  initial begin
    cs = 1'b0; wr = 1'b0; wdata = 8'h00;
    addr_empty = 1'b0; wfifo_empty = 1'b0; rfifo_empty = 1'b0;
    dsp_hreq = 1'b0; dsp_gpio = 1'b0;
    t_reset();
    t_fields();
    t_spare();
    t_nowrite();
    t_status();
    t_irq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule